// File: doc/BRIEF.md
# Boundary-Paused Simple DMA Address Engine

This block is the address-generation half of a simple DMA channel inside an SD host controller. Software programs a start address, a block length, a block count and a buffer-boundary code through a small word-wide register port. It then starts the transfer by writing the transfer-mode word with the enable bit set. The engine issues one word request per beat on a request/grant memory interface. The address advances by four bytes on every granted beat, and the block count is decremented at the end of each block.

Whenever a granted beat leaves the address on a multiple of the programmed boundary (4 KiB shifted left by the 3-bit code) and the transfer is not yet finished, the engine stops issuing requests and raises a DMA status flag. It stays stopped until software writes the address register again. The written value becomes the next address, so writing back the value read from the register resumes the transfer in place. When the last word of the last block is granted, the engine raises a transfer-complete flag and returns to idle. Both status flags are cleared by writing ones to them.

Top module: `sdma_engine`

## Requirements
- R1: After reset the current address, the size word, the mode word and the status word all read 0, and no memory request is issued.
- R2: The register map is as follows. Offset 0x00 holds the 32-bit address. Offset 0x04 holds the block size in bits 11:0, the boundary code in bits 14:12 and the block count in bits 31:16. Offset 0x0C holds the mode word: bit 0 DMA enable, bit 1 block-counter enable, bit 4 card-to-host direction, bit 5 multi-block. Offset 0x30 holds the status word: bit 1 transfer complete, bit 3 DMA boundary. All of these read back at the same positions.
- R3: A write to the mode word with bit 0 set, made while idle, starts a transfer. Requests go out at consecutive word addresses (step 4), beginning at the current address. A request and its address are held stable until granted.
- R4: The memory write indication `memWr` equals mode bit 4, so card-to-host transfers write memory.
- R5: A block spans ceil(size/4) words, with a minimum of one word.
- R6: With mode bit 5 clear the transfer ends after one block. With bits 5 and 1 set it ends after the block in which the count reaches 0. When bit 1 is set, the count is decremented by one at the end of each block.
- R7: When the last word is granted, status bit 1 is set and requests stop. The address register then reads the word after the last one transferred.
- R8: If a granted, non-final beat leaves the address on a multiple of 4 KiB << code, the engine sets status bit 3 and issues no further request. The address register reads the next address to be transferred.
- R9: The start address never causes a pause, even when it is aligned. A transfer whose final beat lands on a boundary completes without a pause.
- R10: While paused, a write to offset 0x00 resumes the transfer from the written address. Writing back the current value continues in place.
- R11: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write offset |
| regWrData | input | 32 | Register write data |
| rdAddr | input | 8 | Register read offset |
| rdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Word transfer request |
| memGnt | input | 1 | Request accepted this cycle |
| memAddr | output | 32 | Byte address of the requested word |
| memWr | output | 1 | 1: write to memory (card to host) |

## Verification
The bench builds the engine with its default parameters: a 32-bit address, a 12-bit block size, a 16-bit count and a 4 KiB base boundary. With these values, start addresses just below 0x1000, 0x5000 and similar bring the boundary codes 0 and 1 within a few beats. Short block sizes bring the ceiling rule, the block-count decrement and the end-on-boundary case within a few dozen cycles. Grant stalls from a pseudo-random pattern exercise the hold behaviour of requests during multi-block runs.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam logic [7:0] OFF_ADDR = 8'h00;
  localparam logic [7:0] OFF_SIZE = 8'h04;
  localparam logic [7:0] OFF_MODE = 8'h0C;
  localparam logic [7:0] OFF_STAT = 8'h30;

  localparam int MODE_EN    = 0;
  localparam int MODE_CNT   = 1;
  localparam int MODE_DIR   = 4;
  localparam int MODE_MULTI = 5;

  localparam int STAT_DONE = 1;
  localparam int STAT_DMA  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } engState_t;

  typedef struct packed {
    logic clrOffset;
    logic advance;
    logic blockEnd;
    logic raiseDma;
    logic raiseDone;
  } ctlStrobes_t;

endpackage

// File: rtl/sdma_dpath.sv
module sdma_dpath
  import sdma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SIZE_W        = 12,
  parameter int BND_W         = 3,
  parameter int CNT_W         = 16,
  parameter int BND_BASE_LOG2 = 12,
  parameter int WORD_BYTES    = 4,
  parameter int REG_AW        = 8,
  parameter int REG_DW        = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [REG_DW-1:0]  regWrData,
  input  logic [REG_AW-1:0]  rdAddr,
  output logic [REG_DW-1:0]  rdData,
  input  ctlStrobes_t        strobes,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               dirToMem,
  output logic               startReq,
  output logic               addrWrite,
  output logic               beatLast,
  output logic               blockLast,
  output logic               boundaryHit,
  output logic               dmaInt,
  output logic               xferDone
);

  localparam int OFF_W   = SIZE_W + 1;
  localparam int BND_LSB = SIZE_W;
  localparam int CNT_LSB = REG_DW / 2;

  logic [SIZE_W-1:0] blkSize;
  logic [BND_W-1:0]  bndCode;
  logic [CNT_W-1:0]  blkCnt;
  logic [OFF_W-1:0]  byteOff;
  logic [OFF_W-1:0]  offNext;
  logic              modeEn, modeCnt, modeDir, modeMulti;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] bndMask;
  logic              wrSize, wrMode, wrStat;
  logic              unusedBits;

  assign addrWrite = regWe && (regAddr == REG_AW'(OFF_ADDR));
  assign wrSize    = regWe && (regAddr == REG_AW'(OFF_SIZE));
  assign wrMode    = regWe && (regAddr == REG_AW'(OFF_MODE));
  assign wrStat    = regWe && (regAddr == REG_AW'(OFF_STAT));
  assign startReq  = wrMode && regWrData[MODE_EN];
  assign unusedBits = ^regWrData;

  assign nextAddr    = curAddr + ADDR_W'(WORD_BYTES);
  assign bndMask     = (ADDR_W'(1) << (BND_BASE_LOG2 + int'(bndCode))) - ADDR_W'(1);
  assign boundaryHit = (nextAddr & bndMask) == '0;
  assign offNext     = byteOff + OFF_W'(WORD_BYTES);
  assign beatLast    = offNext >= OFF_W'(blkSize);
  assign blockLast   = !modeMulti || (modeCnt && (blkCnt <= CNT_W'(1)));
  assign dirToMem    = modeDir;

  // Address register: software write has priority over beat advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               curAddr <= '0;
    else if (addrWrite)      curAddr <= regWrData[ADDR_W-1:0];
    else if (strobes.advance) curAddr <= nextAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkSize <= '0;
      bndCode <= '0;
      blkCnt  <= '0;
    end else if (wrSize) begin
      blkSize <= regWrData[SIZE_W-1:0];
      bndCode <= regWrData[BND_LSB +: BND_W];
      blkCnt  <= regWrData[CNT_LSB +: CNT_W];
    end else if (strobes.blockEnd && modeCnt && (blkCnt != '0)) begin
      blkCnt  <= blkCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn    <= 1'b0;
      modeCnt   <= 1'b0;
      modeDir   <= 1'b0;
      modeMulti <= 1'b0;
    end else if (wrMode) begin
      modeEn    <= regWrData[MODE_EN];
      modeCnt   <= regWrData[MODE_CNT];
      modeDir   <= regWrData[MODE_DIR];
      modeMulti <= regWrData[MODE_MULTI];
    end
  end

  // Byte offset inside the current block
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   byteOff <= '0;
    else if (strobes.clrOffset || strobes.blockEnd) byteOff <= '0;
    else if (strobes.advance)                    byteOff <= offNext;
  end

  // Status flags: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaInt   <= 1'b0;
      xferDone <= 1'b0;
    end else begin
      if (strobes.raiseDma)                      dmaInt <= 1'b1;
      else if (wrStat && regWrData[STAT_DMA])    dmaInt <= 1'b0;
      if (strobes.raiseDone)                     xferDone <= 1'b1;
      else if (wrStat && regWrData[STAT_DONE])   xferDone <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      REG_AW'(OFF_ADDR): rdData[ADDR_W-1:0] = curAddr;
      REG_AW'(OFF_SIZE): begin
        rdData[SIZE_W-1:0]       = blkSize;
        rdData[BND_LSB +: BND_W] = bndCode;
        rdData[CNT_LSB +: CNT_W] = blkCnt;
      end
      REG_AW'(OFF_MODE): begin
        rdData[MODE_EN]    = modeEn;
        rdData[MODE_CNT]   = modeCnt;
        rdData[MODE_DIR]   = modeDir;
        rdData[MODE_MULTI] = modeMulti;
      end
      REG_AW'(OFF_STAT): begin
        rdData[STAT_DONE] = xferDone;
        rdData[STAT_DMA]  = dmaInt;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        addrWrite,
  input  logic        memGnt,
  input  logic        beatLast,
  input  logic        blockLast,
  input  logic        boundaryHit,
  output logic        memReq,
  output logic        paused,
  output ctlStrobes_t strobes
);

  engState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_RUN);
  assign paused = (state == ST_PAUSE);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.clrOffset = 1'b1;
          stateNext         = ST_RUN;
        end
      end
      ST_RUN: begin
        if (memGnt) begin
          strobes.advance = 1'b1;
          if (beatLast) strobes.blockEnd = 1'b1;
          if (beatLast && blockLast) begin
            strobes.raiseDone = 1'b1;
            stateNext         = ST_IDLE;
          end else if (boundaryHit) begin
            strobes.raiseDma = 1'b1;
            stateNext        = ST_PAUSE;
          end
        end
      end
      ST_PAUSE: begin
        if (addrWrite) stateNext = ST_RUN;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SIZE_W        = 12,
  parameter int BND_W         = 3,
  parameter int CNT_W         = 16,
  parameter int BND_BASE_LOG2 = 12,
  parameter int WORD_BYTES    = 4,
  parameter int REG_AW        = 8,
  parameter int REG_DW        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [REG_DW-1:0] rdData,
  output logic              memReq,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWr
);

  ctlStrobes_t strobes;
  logic startReq, addrWrite, beatLast, blockLast, boundaryHit;
  logic dmaInt, xferDone, paused;

  sdma_dpath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BND_W(BND_W), .CNT_W(CNT_W),
    .BND_BASE_LOG2(BND_BASE_LOG2), .WORD_BYTES(WORD_BYTES),
    .REG_AW(REG_AW), .REG_DW(REG_DW)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .rdAddr(rdAddr), .rdData(rdData),
    .strobes(strobes), .curAddr(memAddr), .dirToMem(memWr),
    .startReq(startReq), .addrWrite(addrWrite), .beatLast(beatLast),
    .blockLast(blockLast), .boundaryHit(boundaryHit),
    .dmaInt(dmaInt), .xferDone(xferDone)
  );

  sdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .addrWrite(addrWrite),
    .memGnt(memGnt), .beatLast(beatLast), .blockLast(blockLast),
    .boundaryHit(boundaryHit), .memReq(memReq), .paused(paused),
    .strobes(strobes)
  );

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic              memReq,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic              paused,
  input logic              dmaInt,
  input logic              xferDone
);

  logic addrWr;
  assign addrWr = regWe && (regAddr == '0);

  // R3: an ungranted request stays up with a stable address
  a_r3_hold_until_grant: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt && !addrWr) |=> (memReq && $stable(memAddr)));

  // R3: a granted beat moves the address on by one word
  a_r3_word_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt && !addrWr) |=> (memAddr == $past(memAddr) + ADDR_W'(4)));

  // R8: no request while paused
  a_r8_quiet_when_paused: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> !memReq);

  // R8: entering the pause raises the DMA flag on at least a 4 KiB boundary
  a_r8_pause_flags: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paused) |-> (dmaInt && (memAddr[11:0] == 12'h000)));

  // R7: completion stops the requests
  a_r7_done_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> !memReq);

  // R10: an address write releases the pause
  a_r10_resume: assert property (@(posedge clk) disable iff (!rstN)
    (paused && addrWr) |=> (!paused && memReq));

endmodule

bind sdma_engine sdma_engine_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .memReq(memReq), .memGnt(memGnt), .memAddr(memAddr),
  .paused(paused), .dmaInt(dmaInt), .xferDone(xferDone)
);

// File: tb/sdma_engine_tb_top.sv
module sdma_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        memReq;
  logic        memGnt = 1'b1;
  logic [31:0] memAddr;
  logic        memWr;

  int checks = 0, errors = 0;
  int monChecks = 0, monErrors = 0;
  logic [32:0] expQ[$];
  bit stallMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  sdma_engine dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .rdAddr(rdAddr), .rdData(rdData),
    .memReq(memReq), .memGnt(memGnt), .memAddr(memAddr), .memWr(memWr)
  );

  always #5ns clk = ~clk;

  // grant pattern changes shortly after each rising edge
  always @(posedge clk) begin
    #2ns;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memGnt = stallMode ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memReq && memGnt) begin
      monChecks++;
      if (expQ.size() == 0) begin
        monErrors++;
        $display("FAIL R3 unexpected request: actual addr=%h dir=%b expected none", memAddr, memWr);
      end else begin
        logic [32:0] e;
        e = expQ.pop_front();
        if (memAddr !== e[31:0] || memWr !== e[32]) begin
          monErrors++;
          $display("FAIL R3/R4 beat: actual addr=%h dir=%b expected addr=%h dir=%b",
                   memAddr, memWr, e[31:0], e[32]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a;
    #1ns;
    d = rdData;
  endtask

  task automatic pushBeats(input logic [31:0] start, input int n, input logic dir);
    for (int i = 0; i < n; i++) expQ.push_back({dir, start + 32'(4 * i)});
  endtask

  task automatic waitStatus(input int bitIdx, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      regRead(8'h30, s);
      if (s[bitIdx]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    #1_000_000ns;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + monChecks + 1, errors + monErrors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(8'h30, v); chk("R1 status", v, 32'h0);
    regRead(8'h00, v); chk("R1 address", v, 32'h0);
    regRead(8'h04, v); chk("R1 size word", v, 32'h0);
    regRead(8'h0C, v); chk("R1 mode word", v, 32'h0);
    chk("R1 memReq", {31'b0, memReq}, 32'h0);

    // R3 R5 R7 R9: single block of 16 bytes from an aligned start
    regWrite(8'h04, 32'h0000_0010);
    regWrite(8'h00, 32'h0000_1000);
    pushBeats(32'h1000, 4, 1'b0);
    regWrite(8'h0C, 32'h0000_0001);
    waitStatus(1, ok);
    chk("R7 done seen", {31'b0, ok}, 32'h1);
    chk("R3 all beats", expQ.size(), 0);
    regRead(8'h30, v); chk("R9 aligned start no pause", v, 32'h2);
    regRead(8'h00, v); chk("R7 end address", v, 32'h1010);
    chk("R7 requests stopped", {31'b0, memReq}, 32'h0);
    regWrite(8'h30, 32'h0000_0000);
    regRead(8'h30, v); chk("R11 zero write keeps", v, 32'h2);
    regWrite(8'h30, 32'h0000_0002);
    regRead(8'h30, v); chk("R11 clear done", v, 32'h0);

    // R2 R4 R5 R6: multi-block, counted, card-to-host, with grant stalls
    stallMode = 1'b1;
    regWrite(8'h04, 32'h0003_0006);
    regWrite(8'h00, 32'h0000_2000);
    pushBeats(32'h2000, 6, 1'b1);
    regWrite(8'h0C, 32'h0000_0033);
    regRead(8'h0C, v); chk("R2 mode readback", v, 32'h33);
    chk("R4 direction", {31'b0, memWr}, 32'h1);
    waitStatus(1, ok);
    chk("R6 multi done", {31'b0, ok}, 32'h1);
    chk("R5 ceil words", expQ.size(), 0);
    regRead(8'h04, v); chk("R6 count reaches zero", v, 32'h0000_0006);
    regWrite(8'h30, 32'h0000_0002);
    stallMode = 1'b0;

    // R6: single-block mode with counter still stops after one block
    regWrite(8'h04, 32'h0005_0008);
    regWrite(8'h00, 32'h0000_3000);
    pushBeats(32'h3000, 2, 1'b0);
    regWrite(8'h0C, 32'h0000_0003);
    waitStatus(1, ok);
    chk("R6 single done", {31'b0, ok}, 32'h1);
    chk("R6 single beats", expQ.size(), 0);
    regRead(8'h04, v); chk("R6 count decremented once", v, 32'h0004_0008);
    regWrite(8'h30, 32'h0000_0002);

    // R8 R10 R11: pause at 4 KiB, resume in place
    regWrite(8'h04, 32'h0001_0010);
    regWrite(8'h00, 32'h0000_0FF8);
    pushBeats(32'h0FF8, 2, 1'b0);
    regWrite(8'h0C, 32'h0000_0023);
    waitStatus(3, ok);
    chk("R8 pause flag", {31'b0, ok}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 no request while paused", {31'b0, memReq}, 32'h0);
    end
    chk("R8 beats before pause", expQ.size(), 0);
    regRead(8'h30, v); chk("R8 status", v, 32'h8);
    regRead(8'h00, v); chk("R8 next address", v, 32'h1000);
    regWrite(8'h30, 32'h0000_0008);
    regRead(8'h30, v); chk("R11 clear dma", v, 32'h0);
    pushBeats(32'h1000, 2, 1'b0);
    regWrite(8'h00, 32'h0000_1000);
    waitStatus(1, ok);
    chk("R10 resumed to done", {31'b0, ok}, 32'h1);
    chk("R10 remaining beats", expQ.size(), 0);
    regRead(8'h00, v); chk("R10 end address", v, 32'h1008);
    regWrite(8'h30, 32'h0000_000A);

    // R10: resume at a new address
    regWrite(8'h04, 32'h0001_000C);
    regWrite(8'h00, 32'h0000_4FFC);
    pushBeats(32'h4FFC, 1, 1'b0);
    regWrite(8'h0C, 32'h0000_0023);
    waitStatus(3, ok);
    chk("R8 second pause", {31'b0, ok}, 32'h1);
    pushBeats(32'h8000, 2, 1'b0);
    regWrite(8'h00, 32'h0000_8000);
    waitStatus(1, ok);
    chk("R10 new address done", {31'b0, ok}, 32'h1);
    regRead(8'h00, v); chk("R10 new end address", v, 32'h8008);
    regWrite(8'h30, 32'h0000_000A);

    // R8: code 1 (8 KiB) passes a 4 KiB line without pausing
    regWrite(8'h04, 32'h0001_1010);
    regWrite(8'h00, 32'h0000_0FF8);
    pushBeats(32'h0FF8, 4, 1'b0);
    regWrite(8'h0C, 32'h0000_0023);
    waitStatus(1, ok);
    chk("R8 code1 done", {31'b0, ok}, 32'h1);
    regRead(8'h30, v); chk("R8 code1 no pause", v, 32'h2);
    regWrite(8'h30, 32'h0000_0002);

    // R9: final beat lands on a boundary, no pause
    regWrite(8'h04, 32'h0001_0010);
    regWrite(8'h00, 32'h0000_0FF0);
    pushBeats(32'h0FF0, 4, 1'b0);
    regWrite(8'h0C, 32'h0000_0023);
    waitStatus(1, ok);
    chk("R9 end on boundary done", {31'b0, ok}, 32'h1);
    regRead(8'h30, v); chk("R9 end on boundary no pause", v, 32'h2);
    chk("R9 beats", expQ.size(), 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks + monChecks, errors + monErrors);
    $finish;
  end

endmodule